// File: doc/BRIEF.md
# Arrival-Ordered Event Queue

The block watches a vector of asynchronous event lines and turns each rising edge into a queued event tagged with the number of the line that produced it. A consumer core takes events one at a time through a pop handshake. It always receives the oldest outstanding event, with no priority between lines and no preemption. Each queued event carries a copy of the whole synchronised input vector as it stood in the cycle the edge was detected. The handler therefore sees the exact state that caused the event.

Each line may have at most one event outstanding. A line's pending bit is set when its event enters the queue and is cleared when that event is popped. A rising edge that arrives while its line is pending is not queued. Instead it sets a sticky per-line overflow flag, which stays set until the core clears it with a write-one-to-clear strobe. Because a line never holds two entries, a queue as deep as the number of lines can never fill past capacity. The worst-case wait for any event is therefore bounded by that count.

Top module: `evq_dispatch`

## Requirements
- R1: After reset the queue is empty (`queue_empty` = 1) and every bit of `lost_flags` is 0.
- R2: A line that is low and then sampled high at clock edge k enters the queue at edge k+2. From then on it is visible on `head_line` with `queue_empty` = 0.
- R3: `head_line` always shows the oldest event still queued. Events detected in different cycles leave the queue in the order they were detected.
- R4: Rising edges detected in the same cycle enter the queue in ascending line-number order.
- R5: A rising edge on a line that already has an event queued adds no entry, and it sets bit n of `lost_flags` for that line n.
- R6: A `lost_flags` bit stays set until a cycle with the matching `lost_clr` bit at 1, after which it reads 0. If a new loss on that line is detected in the same cycle as its clear, the bit stays 1.
- R7: When a line's event is popped in the same cycle that a new rising edge on that line is detected, the new edge is queued and no loss is recorded.
- R8: Asserting `pop_ack` while `queue_empty` = 1 has no effect: the queue stays empty, and later events are queued normally.
- R9: `head_snap` shows the synchronised input vector (bit n for line n) from the cycle in which the head event was detected.
- R10: When every line rises in the same cycle, all of them are queued and none is lost.
- R11: A line held high, or a falling edge, queues nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_lines | input | NUM_SRC | Asynchronous event inputs, one per line |
| pop_ack | input | 1 | Removes the head event at the clock edge when the queue is non-empty |
| head_line | output | $clog2(NUM_SRC) | Line number of the oldest queued event |
| head_snap | output | NUM_SRC | Synchronised input vector captured with the head event |
| queue_empty | output | 1 | 1 when no event is queued |
| lost_flags | output | NUM_SRC | Sticky per-line flags for dropped edges |
| lost_clr | input | NUM_SRC | Write-one-to-clear strobes for `lost_flags` |

## Verification
The hardest situations to reach are the ones where two things happen in the same clock: a line's event is popped exactly as a fresh edge on that line is detected, and a clear strobe lands exactly as a new loss on the same line is detected. Both depend on the two-stage synchroniser delay. The stimulus counts edges from the input change: it raises the line, waits two edges, and then asserts `pop_ack` or `lost_clr` for the single edge on which the detection commits. A random phase follows. It toggles lines, pops and clears freely against a behavioural queue model, and so reaches many other same-cycle collisions.

// File: rtl/evq_pkg.sv
package evq_pkg;

  // Widest source vector the helper functions accept.
  localparam int MAX_SRC = 64;

  // Number of set bits in v strictly below bit position pos.
  function automatic int ones_below(logic [MAX_SRC-1:0] v, int pos);
    int c = 0;
    for (int k = 0; k < MAX_SRC; k++) begin
      if (k < pos && v[k]) c++;
    end
    return c;
  endfunction

  // base + off wrapped into [0, depth), for base < depth and off <= depth.
  function automatic int ring_add(int base, int off, int depth);
    int s = base + off;
    if (s >= depth) s -= depth;
    return s;
  endfunction

endpackage

// File: rtl/evq_sync_edge.sv
module evq_sync_edge #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_in,
  output logic [WIDTH-1:0] synced,
  output logic [WIDTH-1:0] rise
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;
  logic [WIDTH-1:0] last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      last_q <= '0;
    end else begin
      meta_q <= raw_in;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  assign synced = sync_q;
  assign rise   = sync_q & ~last_q;

endmodule

// File: rtl/evq_fifo.sv
module evq_fifo
  import evq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] push_vec,
  input  logic [DEPTH-1:0] push_snap,
  input  logic             pop_req,
  output logic [IDX_W-1:0] head_src,
  output logic [DEPTH-1:0] head_snap,
  output logic             empty,
  output logic [CNT_W-1:0] level
);

  logic [IDX_W-1:0] src_q  [DEPTH];
  logic [DEPTH-1:0] snap_q [DEPTH];
  logic [IDX_W-1:0] rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;

  logic             pop_fire;
  logic [CNT_W-1:0] push_cnt;
  logic [IDX_W-1:0] wr_base;
  logic [IDX_W-1:0] slot [DEPTH];

  assign pop_fire = pop_req && (cnt_q != '0);
  assign push_cnt = CNT_W'($countones(push_vec));
  assign wr_base  = IDX_W'(ring_add(int'(rd_ptr_q), int'(cnt_q), DEPTH));

  // Each pushing source takes the slot after all lower-numbered pushers.
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      slot[i] = IDX_W'(ring_add(int'(wr_base), ones_below(MAX_SRC'(push_vec), i), DEPTH));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (pop_fire) rd_ptr_q <= IDX_W'(ring_add(int'(rd_ptr_q), 1, DEPTH));
      cnt_q <= cnt_q + push_cnt - CNT_W'(pop_fire);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (push_vec[i]) begin
        src_q[slot[i]]  <= IDX_W'(i);
        snap_q[slot[i]] <= push_snap;
      end
    end
  end

  assign empty     = (cnt_q == '0);
  assign level     = cnt_q;
  assign head_src  = empty ? '0 : src_q[rd_ptr_q];
  assign head_snap = empty ? '0 : snap_q[rd_ptr_q];

  // R10: occupancy never exceeds one entry per source.
  p_depth_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  // R8: a pop on an empty queue with nothing arriving leaves it untouched.
  p_pop_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && cnt_q == '0 && push_vec == '0) |=> (cnt_q == '0 && $stable(rd_ptr_q)));

endmodule

// File: rtl/evq_dispatch.sv
module evq_dispatch #(
  parameter int NUM_SRC = 8,
  localparam int IDX_W = $clog2(NUM_SRC),
  localparam int CNT_W = $clog2(NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_lines,
  input  logic               pop_ack,
  output logic [IDX_W-1:0]   head_line,
  output logic [NUM_SRC-1:0] head_snap,
  output logic               queue_empty,
  output logic [NUM_SRC-1:0] lost_flags,
  input  logic [NUM_SRC-1:0] lost_clr
);

  logic [NUM_SRC-1:0] synced_vec;
  logic [NUM_SRC-1:0] rise_vec;
  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] lost_q;
  logic [CNT_W-1:0]   level;

  // Named internal events.
  logic               pop_fire;
  logic [NUM_SRC-1:0] pop_clr_vec;
  logic [NUM_SRC-1:0] pend_eff;
  logic [NUM_SRC-1:0] accept_vec;
  logic [NUM_SRC-1:0] drop_vec;

  evq_sync_edge #(.WIDTH(NUM_SRC)) sync_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_in (evt_lines),
    .synced (synced_vec),
    .rise   (rise_vec)
  );

  assign pop_fire    = pop_ack && !queue_empty;
  assign pop_clr_vec = pop_fire ? (NUM_SRC'(1) << head_line) : '0;
  assign pend_eff    = pend_q & ~pop_clr_vec;
  assign accept_vec  = rise_vec & ~pend_eff;
  assign drop_vec    = rise_vec & pend_eff;

  evq_fifo #(.DEPTH(NUM_SRC)) fifo_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_vec  (accept_vec),
    .push_snap (synced_vec),
    .pop_req   (pop_ack),
    .head_src  (head_line),
    .head_snap (head_snap),
    .empty     (queue_empty),
    .level     (level)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      lost_q <= '0;
    end else begin
      pend_q <= pend_eff | accept_vec;
      lost_q <= (lost_q & ~lost_clr) | drop_vec;
    end
  end

  assign lost_flags = lost_q;

  // R5: pending bits and queue occupancy agree, so no source is queued twice.
  p_pend_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pend_q) == int'(level));

  // R3: the event offered at the head belongs to a pending source.
  p_head_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !queue_empty |-> pend_q[head_line]);

  // R6: a loss flag only falls after a clear strobe for that bit.
  p_lost_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(lost_q) & ~$past(lost_clr)) & ~lost_q) == '0));

  // R7: a pop that frees a source never coincides with a loss on it.
  p_pop_no_loss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_clr_vec & drop_vec) == '0);

endmodule

// File: tb/evq_dispatch_tb.sv
module evq_dispatch_tb_top;
  localparam int N = 8;
  localparam int IW = $clog2(N);
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] evt = '0;
  logic [N-1:0] clr = '0;
  logic         pop = 1'b0;
  logic [IW-1:0] head_line;
  logic [N-1:0] head_snap;
  logic         queue_empty;
  logic [N-1:0] lost_flags;

  always #(CLK_PERIOD/2) clk = ~clk;

  evq_dispatch #(.NUM_SRC(N)) dut_i (
    .clk (clk), .rst_n (rst_n), .evt_lines (evt), .pop_ack (pop),
    .head_line (head_line), .head_snap (head_snap), .queue_empty (queue_empty),
    .lost_flags (lost_flags), .lost_clr (clr)
  );

  int n_tests = 0;
  int n_fail  = 0;

  task automatic check(string tag, int act, int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference: a queue of line numbers with captured vectors.
  logic [N-1:0] m_s1 = '0, m_s2 = '0, m_prev = '0, m_pend = '0, m_lost = '0;
  logic [N-1:0] m_rise, m_drop;
  int           m_q[$];
  logic [N-1:0] m_snap[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_pend = '0; m_lost = '0;
      m_q.delete(); m_snap.delete();
    end else begin
      m_rise = m_s2 & ~m_prev;
      m_drop = '0;
      if (pop && m_q.size() > 0) begin
        m_pend[m_q[0]] = 1'b0;
        void'(m_q.pop_front());
        void'(m_snap.pop_front());
      end
      for (int i = 0; i < N; i++) begin
        if (m_rise[i]) begin
          if (m_pend[i]) m_drop[i] = 1'b1;
          else begin
            m_q.push_back(i);
            m_snap.push_back(m_s2);
            m_pend[i] = 1'b1;
          end
        end
      end
      m_lost = (m_lost & ~clr) | m_drop;
      m_prev = m_s2;
      m_s2   = m_s1;
      m_s1   = evt;
    end
  end

  // Every-clock comparison, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      check("R3 queue_empty vs model", int'(queue_empty), int'(m_q.size() == 0));
      if (m_q.size() > 0) begin
        check("R3 head_line vs model", int'(head_line), m_q[0]);
        check("R9 head_snap vs model", int'(head_snap), int'(m_snap[0]));
      end
      check("R5 R6 lost_flags vs model", int'(lost_flags), int'(m_lost));
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    pop = 1'b1;
    while (!queue_empty) tick(1);
    pop = 1'b0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    check("R1 empty after reset", int'(queue_empty), 1);
    check("R1 lost_flags after reset", int'(lost_flags), 0);

    // R2 latency
    evt[3] = 1'b1;
    tick(2);
    check("R2 not yet queued", int'(queue_empty), 1);
    tick(1);
    check("R2 queued", int'(queue_empty), 0);
    check("R2 head line", int'(head_line), 3);

    // R11 held level does not requeue after pop
    pop = 1'b1; tick(1); pop = 1'b0;
    tick(4);
    check("R11 held high queues nothing", int'(queue_empty), 1);
    evt[3] = 1'b0; tick(4);
    check("R11 falling edge queues nothing", int'(queue_empty), 1);

    // R5 repeat edge while pending
    evt[3] = 1'b1; tick(3);
    evt[3] = 1'b0; tick(3);
    evt[3] = 1'b1; tick(3);
    check("R5 loss flagged", int'(lost_flags[3]), 1);
    pop = 1'b1; tick(1); pop = 1'b0;
    check("R5 single entry only", int'(queue_empty), 1);

    // R6 clear
    clr[3] = 1'b1; tick(1); clr = '0;
    check("R6 cleared", int'(lost_flags[3]), 0);

    // R6 new loss in the clear cycle wins
    evt[3] = 1'b0; tick(3);
    evt[3] = 1'b1; tick(3);
    evt[3] = 1'b0; tick(3);
    evt[3] = 1'b1; tick(2);
    clr[3] = 1'b1; tick(1); clr = '0;
    check("R6 new loss beats clear", int'(lost_flags[3]), 1);
    clr[3] = 1'b1; tick(1); clr = '0;
    drain();

    // R3 order across cycles, R9 snapshots
    evt = '0; tick(3);
    evt[5] = 1'b1; tick(1);
    evt[1] = 1'b1; tick(4);
    check("R3 oldest first", int'(head_line), 5);
    check("R9 snapshot of line 5", int'(head_snap), 32);
    pop = 1'b1; tick(1); pop = 1'b0;
    check("R3 next oldest", int'(head_line), 1);
    check("R9 snapshot of line 1", int'(head_snap), 34);
    pop = 1'b1; tick(1); pop = 1'b0;
    check("R3 drained", int'(queue_empty), 1);

    // R4 and R10: all lines at once
    evt = '0; tick(3);
    evt = '1; tick(3);
    for (int k = 0; k < N; k++) begin
      check("R4 R10 ascending pop order", int'(head_line), k);
      pop = 1'b1; tick(1);
    end
    pop = 1'b0;
    check("R10 all delivered", int'(queue_empty), 1);
    check("R10 none lost", int'(lost_flags), 0);

    // R7 pop coincides with new edge on the same line
    evt = '0; tick(3);
    evt[2] = 1'b1; tick(3);
    evt[2] = 1'b0; tick(3);
    evt[2] = 1'b1; tick(2);
    pop = 1'b1; tick(1); pop = 1'b0;
    check("R7 requeued", int'(queue_empty), 0);
    check("R7 head line", int'(head_line), 2);
    check("R7 no loss", int'(lost_flags[2]), 0);
    drain();

    // R8 pop on empty queue
    pop = 1'b1; tick(2); pop = 1'b0;
    check("R8 still empty", int'(queue_empty), 1);
    evt[6] = 1'b1; tick(3);
    check("R8 later event queued", int'(head_line), 6);
    drain();

    // Random phase compared against the model every clock
    for (int c = 0; c < 600; c++) begin
      evt = evt ^ (N'($urandom) & N'($urandom));
      pop = ($urandom % 3) == 0;
      clr = N'($urandom) & N'($urandom) & N'($urandom);
      tick(1);
    end
    clr = '0;
    drain();
    tick(2);

    summary();
    $finish;
  end

endmodule